// File: doc/BRIEF.md
# Gate Driver Protection Sequencer

This block is the digital control core of a single-channel, low-side, non-inverting gate driver. It takes a PWM command, an over-current comparator flag, a supply undervoltage comparator flag (hysteresis is applied before it arrives) and the sampled level of a shared open-drain enable/fault pin. It produces the gate enable and a pull-down request for that pin. All inputs pass through one register stage. Outputs are registered, so a change on an input first shows on the outputs two rising clock edges later.

After every turn-on, the over-current flag is ignored for a blanking window of `BLANK_CYC` cycles. This hides the switching transient. An undervoltage flag counts only after it has stayed high for `UV_FILT_CYC` consecutive samples. A qualifying fault forces the gate low, pulls the shared pin low and latches a cause code. When the cause goes away the pull-down is released. The gate then stays low until the pin is seen high again and a fresh PWM rising edge arrives. If an external device holds the pin low, the gate is disabled but no fault is latched.

Top module: `gdps_top`

## Requirements
- R1: While reset is high and in the cycle after reset is released, `gate_o`=0, `pin_pd_o`=0 and `cause_o`=2'b00. The block starts armed.
- R2: When armed, with no fault and the pin reading high, `gate_o` equals `pwm_i` as sampled two rising edges earlier (non-inverting). A PWM level of 0 always keeps the gate off.
- R3: A low level on `pin_i` that comes from outside, with `pin_pd_o`=0, holds `gate_o` low. It does not latch a fault: `pin_pd_o` stays 0 and `cause_o` stays 2'b00. The gate follows `pwm_i` again as soon as the pin reads high, with no new edge needed.
- R4: For `BLANK_CYC` cycles after each rising edge of `gate_o`, `oc_i` has no effect. The gate keeps following PWM and no fault is latched.
- R5: An `oc_i` high that is sampled while the gate is on and the blanking window has expired drives `gate_o` to 0 and `pin_pd_o` to 1 on the same edge, and sets `cause_o`=2'b01 (over-current).
- R6: A `uv_i` high run shorter than `UV_FILT_CYC` consecutive samples has no effect on any output.
- R7: A `uv_i` run of at least `UV_FILT_CYC` samples forces `gate_o` to 0 and `pin_pd_o` to 1 whatever the PWM level, and sets `cause_o`=2'b10. Undervoltage overrides an over-current cause, including one detected in the same cycle.
- R8: `pin_pd_o` stays high while the latched cause persists. It drops once `oc_i` (over-current cause) or `uv_i` (undervoltage cause) has gone low.
- R9: After release, `gate_o` stays low until `pin_i` is sampled high and, after that, a PWM rising edge (a 0 sample followed by a 1 sample) is seen. A PWM level that is already high at release does not turn the gate on. `cause_o` keeps the cause until this re-arm and returns to 2'b00 at the re-arm.
- R10: `gate_o` and `pin_pd_o` are never high together, and `cause_o` never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command, 1 = gate on |
| oc_i | input | 1 | Over-current comparator flag, 1 = over threshold |
| uv_i | input | 1 | Supply undervoltage flag, 1 = supply low |
| pin_i | input | 1 | Sampled level of the shared enable/fault pin |
| gate_o | output | 1 | Gate drive enable, registered |
| pin_pd_o | output | 1 | Open-drain pull-down request for the shared pin, registered |
| cause_o | output | 2 | Latched fault cause: 00 none, 01 over-current, 10 undervoltage |

## Verification
The assertions assume that the shared pin is wired as an open drain. In that wiring `pin_i` can only read high when `pin_pd_o` is low, and every input is synchronous to `clk`. The bench models the pin as the AND of an external enable level and the inverse of `pin_pd_o`. It changes all inputs only at the falling clock edge. Undervoltage runs are generated both shorter and longer than the filter length. Over-current pulses land both inside and outside the blanking window, so both sides of each timing limit are exercised.

// File: rtl/gdps_pkg.sv
package gdps_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TRIP = 2'd1,
    ST_REL  = 2'd2,
    ST_ARM  = 2'd3
  } gd_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OC   = 2'b01,
    CAUSE_UV   = 2'b10
  } gd_cause_e;
endpackage

// File: rtl/gdps_in_stage.sv
module gdps_in_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/gdps_uv_filter.sv
module gdps_uv_filter #(
  parameter int UV_FILT_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_q,
  output logic uv_acc
);
  localparam int CW = $clog2(UV_FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(UV_FILT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(UV_FILT_CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !uv_q) begin
      run_cnt <= '0;
      uv_acc  <= 1'b0;
    end else begin
      if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
      if (run_cnt == LAST)  uv_acc  <= 1'b1;
    end
  end
endmodule

// File: rtl/gdps_blank.sv
module gdps_blank #(
  parameter int BLANK_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic blank_act
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC);

  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)             left <= '0;
    else if (start)      left <= LOAD;
    else if (left != '0) left <= left - 1'b1;
  end

  assign blank_act = (left != '0);
endmodule

// File: rtl/gdps_ctrl.sv
module gdps_ctrl
  import gdps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_q,
  input  logic       oc_q,
  input  logic       pin_q,
  input  logic       uv_acc,
  input  logic       blank_act,
  output logic       gate_o,
  output logic       pin_pd_o,
  output logic [1:0] cause_o,
  output logic       gate_start
);
  gd_state_e state, state_n;
  gd_cause_e cause, cause_n;
  logic      pwm_prev;
  logic      oc_hit;
  logic      pwm_edge;
  logic      gate_d;

  assign oc_hit   = gate_o && !blank_act && oc_q;
  assign pwm_edge = pwm_q && !pwm_prev;

  always_comb begin
    state_n = state;
    cause_n = cause;
    unique case (state)
      ST_RUN: begin
        if (uv_acc) begin
          state_n = ST_TRIP;
          cause_n = CAUSE_UV;
        end else if (oc_hit) begin
          state_n = ST_TRIP;
          cause_n = CAUSE_OC;
        end
      end
      ST_TRIP: begin
        if (uv_acc)                             cause_n = CAUSE_UV;
        else if (cause == CAUSE_UV || !oc_q)    state_n = ST_REL;
      end
      ST_REL: begin
        if (uv_acc) begin
          state_n = ST_TRIP;
          cause_n = CAUSE_UV;
        end else if (pin_q) begin
          state_n = ST_ARM;
        end
      end
      ST_ARM: begin
        if (uv_acc) begin
          state_n = ST_TRIP;
          cause_n = CAUSE_UV;
        end else if (!pin_q) begin
          state_n = ST_REL;
        end else if (pwm_edge) begin
          state_n = ST_RUN;
          cause_n = CAUSE_NONE;
        end
      end
      default: state_n = ST_TRIP;
    endcase
  end

  assign gate_d     = (state_n == ST_RUN) && pwm_q && pin_q;
  assign gate_start = gate_d && !gate_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      cause    <= CAUSE_NONE;
      pwm_prev <= 1'b0;
      gate_o   <= 1'b0;
      pin_pd_o <= 1'b0;
    end else begin
      state    <= state_n;
      cause    <= cause_n;
      pwm_prev <= pwm_q;
      gate_o   <= gate_d;
      pin_pd_o <= (state_n == ST_TRIP);
    end
  end

  assign cause_o = cause;
endmodule

// File: rtl/gdps_top.sv
module gdps_top #(
  parameter int BLANK_CYC   = 18,
  parameter int UV_FILT_CYC = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_i,
  input  logic       oc_i,
  input  logic       uv_i,
  input  logic       pin_i,
  output logic       gate_o,
  output logic       pin_pd_o,
  output logic [1:0] cause_o
);
  localparam int NIN = 4;

  logic [NIN-1:0] raw_in, reg_in;
  logic pwm_q, oc_q, uv_q, pin_q;
  logic uv_acc, blank_act, gate_start;

  assign raw_in = {pin_i, uv_i, oc_i, pwm_i};
  assign {pin_q, uv_q, oc_q, pwm_q} = reg_in;

  gdps_in_stage #(.W(NIN)) u_in (
    .clk (clk), .rst (rst), .d (raw_in), .q (reg_in)
  );

  gdps_uv_filter #(.UV_FILT_CYC(UV_FILT_CYC)) u_uv (
    .clk (clk), .rst (rst), .uv_q (uv_q), .uv_acc (uv_acc)
  );

  gdps_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk (clk), .rst (rst), .start (gate_start), .blank_act (blank_act)
  );

  gdps_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pwm_q      (pwm_q),
    .oc_q       (oc_q),
    .pin_q      (pin_q),
    .uv_acc     (uv_acc),
    .blank_act  (blank_act),
    .gate_o     (gate_o),
    .pin_pd_o   (pin_pd_o),
    .cause_o    (cause_o),
    .gate_start (gate_start)
  );
endmodule

// File: rtl/gdps_checker.sv
module gdps_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwm_i,
  input logic       pin_i,
  input logic       gate_o,
  input logic       pin_pd_o,
  input logic [1:0] cause_o,
  input logic       uv_acc,
  input logic       oc_q,
  input logic       blank_act
);
  // R2: gate on only when PWM was high two edges before
  p_gate_pwm_r2: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> $past(pwm_i, 2));

  // R3: gate on only when the pin read high two edges before
  p_gate_pin_r3: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> $past(pin_i, 2));

  // R4: every turn-on opens a blanking window
  p_blank_open_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> blank_act);

  // R5: a new pull-down has a qualified cause behind it
  p_pd_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_pd_o) |-> ($past(uv_acc) || $past(oc_q)));

  // R7: accepted undervoltage shuts the gate and pulls the pin
  p_uv_shut_r7: assert property (@(posedge clk) disable iff (rst)
    uv_acc |=> (!gate_o && pin_pd_o && cause_o == 2'b10));

  // R10: gate and pull-down exclusive, cause code legal
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(gate_o && pin_pd_o) && (cause_o != 2'b11));
endmodule

bind gdps_top gdps_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwm_i     (pwm_i),
  .pin_i     (pin_i),
  .gate_o    (gate_o),
  .pin_pd_o  (pin_pd_o),
  .cause_o   (cause_o),
  .uv_acc    (uv_acc),
  .oc_q      (oc_q),
  .blank_act (blank_act)
);

// File: tb/tb_gdps_top.sv
module tb_gdps_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 4;
  localparam int UVF   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0, oc = 1'b0, uv = 1'b0, ext_en = 1'b1;
  logic pin;
  logic gate, pd;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin = ext_en & ~pd;

  gdps_top #(.BLANK_CYC(BLANK), .UV_FILT_CYC(UVF)) dut (
    .clk (clk), .rst (rst), .pwm_i (pwm), .oc_i (oc), .uv_i (uv),
    .pin_i (pin), .gate_o (gate), .pin_pd_o (pd), .cause_o (cause)
  );

  // Reference model built from the requirements
  logic m_pwm_q, m_oc_q, m_uv_q, m_pin_q, m_pwm_p, m_uva, m_gate, m_pd;
  int   m_uvc, m_bc, m_st;
  logic [1:0] m_cause;

  always @(posedge clk) begin
    if (rst) begin
      m_pwm_q = 0; m_oc_q = 0; m_uv_q = 0; m_pin_q = 0; m_pwm_p = 0;
      m_uva = 0; m_gate = 0; m_pd = 0; m_uvc = 0; m_bc = 0; m_st = 0;
      m_cause = 2'b00;
    end else begin
      logic hit, g_n, pin_now;
      int st_n;
      logic [1:0] c_n;
      hit = m_gate && (m_bc == 0) && m_oc_q;
      st_n = m_st; c_n = m_cause;
      case (m_st)
        0: if (m_uva) begin st_n = 1; c_n = 2'b10; end
           else if (hit) begin st_n = 1; c_n = 2'b01; end
        1: if (m_uva) c_n = 2'b10;
           else if (m_cause == 2'b10 || !m_oc_q) st_n = 2;
        2: if (m_uva) begin st_n = 1; c_n = 2'b10; end
           else if (m_pin_q) st_n = 3;
        default: if (m_uva) begin st_n = 1; c_n = 2'b10; end
           else if (!m_pin_q) st_n = 2;
           else if (m_pwm_q && !m_pwm_p) begin st_n = 0; c_n = 2'b00; end
      endcase
      g_n = (st_n == 0) && m_pwm_q && m_pin_q;
      if (g_n && !m_gate) m_bc = BLANK;
      else if (m_bc > 0)  m_bc = m_bc - 1;
      if (!m_uv_q) begin m_uvc = 0; m_uva = 0; end
      else begin
        if (m_uvc == UVF - 1) m_uva = 1;
        if (m_uvc != UVF) m_uvc = m_uvc + 1;
      end
      pin_now = ext_en & ~m_pd;
      m_pwm_p = m_pwm_q; m_pwm_q = pwm; m_oc_q = oc; m_uv_q = uv;
      m_pin_q = pin_now;
      m_st = st_n; m_cause = c_n; m_gate = g_n; m_pd = (st_n == 1);
    end
  end

  task automatic chk(input string t, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // advance one cycle and compare all outputs with the model
  task automatic step();
    @(negedge clk);
    chk({tag, " gate"},  {1'b0, gate}, {1'b0, m_gate});
    chk({tag, " pd"},    {1'b0, pd},   {1'b0, m_pd});
    chk({tag, " cause"}, cause, m_cause);
    chk("R10 exclusive", {1'b0, gate & pd}, 2'b00);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", {1'b0, gate}, 2'b00);
    chk("R1 pd in reset", {1'b0, pd}, 2'b00);
    rst = 1'b0;
    tag = "R1"; step();
    chk("R1 cause after reset", cause, 2'b00);

    // R2: follow PWM
    tag = "R2";
    pwm = 1; steps(3);
    chk("R2 gate on", {1'b0, gate}, 2'b01);
    pwm = 0; steps(3);
    chk("R2 gate off", {1'b0, gate}, 2'b00);
    pwm = 1; steps(2); pwm = 0; steps(2); pwm = 1; steps(6);

    // R3: external disable, no latch, resume on level
    tag = "R3";
    ext_en = 0; steps(4);
    chk("R3 gate off", {1'b0, gate}, 2'b00);
    chk("R3 no latch", cause, 2'b00);
    ext_en = 1; steps(3);
    chk("R3 resume", {1'b0, gate}, 2'b01);

    // R4: oc inside blanking ignored
    tag = "R4";
    pwm = 0; steps(3);
    pwm = 1; oc = 1; steps(3); oc = 0; steps(4);
    chk("R4 no trip", cause, 2'b00);
    chk("R4 gate still on", {1'b0, gate}, 2'b01);

    // R5: oc after blanking trips
    tag = "R5";
    steps(BLANK + 2);
    oc = 1; steps(3);
    chk("R5 cause oc", cause, 2'b01);
    chk("R5 pd", {1'b0, pd}, 2'b01);
    chk("R5 gate", {1'b0, gate}, 2'b00);

    // R8 release, R9 no re-arm on held level
    tag = "R8";
    oc = 0; steps(4);
    chk("R8 released", {1'b0, pd}, 2'b00);
    tag = "R9";
    steps(6);
    chk("R9 held level no rearm", {1'b0, gate}, 2'b00);
    chk("R9 cause kept", cause, 2'b01);
    pwm = 0; steps(2); pwm = 1; steps(3);
    chk("R9 rearm on edge", {1'b0, gate}, 2'b01);
    chk("R9 cause cleared", cause, 2'b00);

    // R6: short undervoltage ignored
    tag = "R6";
    uv = 1; steps(UVF - 1); uv = 0; steps(4);
    chk("R6 short dip", cause, 2'b00);
    chk("R6 gate on", {1'b0, gate}, 2'b01);

    // R7: long undervoltage
    tag = "R7";
    uv = 1; steps(UVF + 4);
    chk("R7 cause uv", cause, 2'b10);
    chk("R7 gate off", {1'b0, gate}, 2'b00);
    chk("R7 pd", {1'b0, pd}, 2'b01);
    oc = 1; steps(3);
    chk("R7 uv priority", cause, 2'b10);
    uv = 0; oc = 0; pwm = 0; steps(5);
    chk("R8 uv release", {1'b0, pd}, 2'b00);
    pwm = 1; steps(3);

    // Random mix checked against the model
    tag = "R10 random";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 5) == 0) pwm = ~pwm;
      oc = ($urandom_range(0, 11) == 0) ? 1'b1 : (oc & ($urandom_range(0, 2) != 0));
      if ($urandom_range(0, 60) == 0) uv = ~uv;
      ext_en = ($urandom_range(0, 40) != 0);
      step();
    end
    uv = 0; oc = 0; ext_en = 1; steps(UVF + 4);
    finish_run();
  end
endmodule